// File: doc/BRIEF.md
# IR Pulse/Space Run-Length Combiner

This block sits behind an infrared receiver's sampler. Each raw sample is a count of sampler periods with a polarity (mark or space). The block scales the count to microseconds, merges neighbouring samples of the same polarity into one run, and emits each finished run as a 32-bit word. The word carries the magnitude and a flag that says whether the run was a mark. A downstream decoder reads these words to recover the remote-control protocol timing.

Long silences need their own handling. The sampler keeps reporting a saturated "overflow" count while the line stays quiet. Once the accumulated space passes a threshold, the block goes idle and ignores further overflows. The next real sample ends the idle period. At that point the block reports the whole silence as one space, built from the accumulated space plus the microseconds counted while idle. It can optionally drop that first sample, because its length is meaningless after a gap.

A second input format is also accepted. It carries 16-bit wide samples with a fixed sample period and has no overflow or idle handling.

Top module: `ir_run_combiner`

## Requirements
- R1: After reset the output is silent (out_valid low), in_ready is high, and the block is idle with a gap count of zero.
- R2: Narrow format: bits 6..0 hold the count and bit 7 set means space. The run length is count × period_us. Output words put the magnitude in bits 23..0, set bit 24 for a mark and hold bits 31..25 at zero.
- R3: Wide format (wide_mode high): bit 15 set means mark, bits 11..0 hold the count, and the period is fixed at 61 µs.
- R4: A sample whose count field is zero is ignored: it produces no word and leaves the accumulated run unchanged.
- R5: A non-overflow sample is merged into the accumulated run if both have the same polarity, and the sum is emitted at once. If the polarities differ, the accumulated run is emitted first and the new sample follows on the next cycle. The accumulator is empty afterwards.
- R6: A narrow overflow sample (count 127) that arrives while not idle is accumulated without emitting anything. This applies when the accumulator is empty, holds a mark, or holds a space of at most 250000 µs. If the overflow's polarity differs from a non-empty accumulator, the accumulator is emitted and then reloaded with the overflow.
- R7: An overflow that arrives while the accumulator holds a space longer than 250000 µs puts the block into idle. That overflow is discarded, no word is emitted, and the gap count restarts at zero.
- R8: While idle, overflow samples produce no word, and the gap count is not affected by them.
- R9: While idle, each us_tick cycle adds one to the gap count. The first non-overflow narrow sample ends idle and emits a space equal to the accumulated space plus the gap count. The accumulator is then empty.
- R10: With idle_drop high, the sample that ends idle is discarded. With idle_drop low, it is emitted as its own word on the cycle after the gap word.
- R11: All magnitudes, whether accumulated, summed or reported as a gap, saturate at 0xFFFFFF.
- R12: In wide mode, a count of 127 is an ordinary sample and the idle state is neither entered nor left.
- R13: in_ready is low for exactly the cycle in which a second word waits to be emitted. out_valid is a one-cycle pulse per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Raw sample (narrow or wide format) |
| wide_mode | input | 1 | Select the wide 16-bit format |
| idle_drop | input | 1 | Discard the sample that ends idle |
| period_us | input | 8 | Narrow sample period in µs |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| out_valid | output | 1 | Output word valid (one-cycle pulse) |
| out_word | output | 32 | Run word: magnitude [23:0], mark flag [24] |

## Verification
Directed sequences cover several distinct patterns. Alternating polarities show the merge path apart from the flush-then-reload path, and the flush-then-reload case must produce two words in back-to-back cycles. Runs of overflows are used in three ways: to grow a mark without limit until it hits saturation, to build a space that crosses the idle threshold, and to arrive while idle, where they must change nothing. The wake-up sample is sent with idle_drop both high and low, which separates dropping it from emitting it after the gap. Wide samples, including the count 127, show that this mode skips the overflow and idle rules. Random mixes of polarity, period, zero counts, overflows and tick spacing are then compared word for word against a reference model in the bench.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam int MAG_W     = 24;
  localparam int WORD_W    = 32;
  localparam int MARK_POS  = 24;

  typedef logic [MAG_W-1:0]  mag_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam mag_t MAG_MAX = '1;

  function automatic mag_t sat_add(input mag_t a, input mag_t b);
    logic [MAG_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MAG_W] ? MAG_MAX : s[MAG_W-1:0];
  endfunction

  function automatic word_t pack_word(input mag_t m, input logic mark);
    word_t w;
    w = '0;
    w[MAG_W-1:0] = m;
    w[MARK_POS]  = mark;
    return w;
  endfunction
endpackage

// File: rtl/ir_sample_decode.sv
module ir_sample_decode
  import ir_rl_pkg::*;
#(
  parameter int IN_W           = 16,
  parameter int PERIOD_W       = 8,
  parameter int NARROW_VAL_W   = 7,
  parameter int WIDE_VAL_W     = 12,
  parameter int WIDE_PERIOD_US = 61
) (
  input  logic [IN_W-1:0]     sample,
  input  logic                wide,
  input  logic [PERIOD_W-1:0] period,
  output mag_t                mag,
  output logic                mark,
  output logic                ovf,
  output logic                empty
);
  localparam int SPACE_BIT = NARROW_VAL_W;

  logic [NARROW_VAL_W-1:0] nval;
  logic [WIDE_VAL_W-1:0]   wval;
  logic                    unused_bits;

  assign nval        = sample[NARROW_VAL_W-1:0];
  assign wval        = sample[WIDE_VAL_W-1:0];
  assign unused_bits = ^sample[IN_W-2:WIDE_VAL_W];

  always_comb begin
    if (wide) begin
      mag   = mag_t'(wval) * mag_t'(WIDE_PERIOD_US);
      mark  = sample[IN_W-1];
      ovf   = 1'b0;
      empty = (wval == '0);
    end else begin
      mag   = mag_t'(nval) * mag_t'(period);
      mark  = ~sample[SPACE_BIT];
      ovf   = (nval == '1);
      empty = (nval == '0);
    end
  end
endmodule

// File: rtl/ir_gap_timer.sv
module ir_gap_timer
  import ir_rl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clear,
  output mag_t gap
);
  always_ff @(posedge clk) begin
    if (rst)                                   gap <= '0;
    else if (clear)                            gap <= '0;
    else if (run && tick && gap != MAG_MAX)    gap <= gap + 1'b1;
  end

  assert_gap_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (gap == MAG_MAX && !clear) |=> gap == MAG_MAX);

  assert_gap_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(gap));
endmodule

// File: rtl/ir_word_out.sv
module ir_word_out
  import ir_rl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  a_v,
  input  word_t a_w,
  input  logic  b_v,
  input  word_t b_w,
  output logic  out_valid,
  output word_t out_word,
  output logic  pend
);
  word_t pend_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      pend      <= 1'b0;
      pend_w    <= '0;
    end else if (pend) begin
      out_valid <= 1'b1;
      out_word  <= pend_w;
      pend      <= 1'b0;
    end else if (a_v) begin
      out_valid <= 1'b1;
      out_word  <= a_w;
      pend      <= b_v;
      pend_w    <= b_w;
    end else begin
      out_valid <= 1'b0;
    end
  end

  assert_drain_R13: assert property (@(posedge clk) disable iff (rst)
    pend |=> (out_valid && !pend));

  assert_pair_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> out_valid);
endmodule

// File: rtl/ir_run_combiner.sv
module ir_run_combiner
  import ir_rl_pkg::*;
#(
  parameter int IN_W           = 16,
  parameter int PERIOD_W       = 8,
  parameter int WIDE_PERIOD_US = 61,
  parameter int MAX_GAP_US     = 250000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_W-1:0]     in_sample,
  input  logic                wide_mode,
  input  logic                idle_drop,
  input  logic [PERIOD_W-1:0] period_us,
  input  logic                us_tick,
  output logic                out_valid,
  output logic [31:0]         out_word
);
  localparam mag_t GAP_LIMIT = mag_t'(MAX_GAP_US);

  mag_t  d_mag, gap, acc_mag, acc_n;
  logic  d_mark, d_ovf, d_empty;
  logic  acc_mark, accm_n, acc_nz;
  logic  idle, idle_n, gap_clr, pend, take;
  logic  a_v, b_v;
  word_t a_w, b_w;

  ir_sample_decode #(
    .IN_W(IN_W), .PERIOD_W(PERIOD_W), .WIDE_PERIOD_US(WIDE_PERIOD_US)
  ) u_dec (
    .sample(in_sample), .wide(wide_mode), .period(period_us),
    .mag(d_mag), .mark(d_mark), .ovf(d_ovf), .empty(d_empty)
  );

  ir_gap_timer u_gap (
    .clk(clk), .rst(rst), .tick(us_tick), .run(idle), .clear(gap_clr), .gap(gap)
  );

  ir_word_out u_out (
    .clk(clk), .rst(rst), .a_v(a_v), .a_w(a_w), .b_v(b_v), .b_w(b_w),
    .out_valid(out_valid), .out_word(out_word), .pend(pend)
  );

  assign in_ready = ~pend;
  assign take     = in_valid & in_ready;
  assign acc_nz   = (acc_mag != '0);

  always_comb begin
    a_v = 1'b0; a_w = '0; b_v = 1'b0; b_w = '0;
    acc_n = acc_mag; accm_n = acc_mark; idle_n = idle; gap_clr = 1'b0;
    if (take && !d_empty) begin
      if (d_ovf) begin
        if (!idle) begin
          if (!acc_nz || acc_mark || acc_mag <= GAP_LIMIT) begin
            if (acc_nz && acc_mark != d_mark) begin
              a_v   = 1'b1;
              a_w   = pack_word(acc_mag, acc_mark);
              acc_n = d_mag;
            end else begin
              acc_n = sat_add(acc_mag, d_mag);
            end
            accm_n = d_mark;
          end else begin
            idle_n  = 1'b1;
            gap_clr = 1'b1;
          end
        end
      end else if (idle && !wide_mode) begin
        a_v    = 1'b1;
        a_w    = pack_word(sat_add(acc_mag, gap), 1'b0);
        acc_n  = '0;
        accm_n = 1'b0;
        idle_n = 1'b0;
        if (!idle_drop) begin
          b_v = 1'b1;
          b_w = pack_word(d_mag, d_mark);
        end
      end else begin
        acc_n  = '0;
        accm_n = 1'b0;
        a_v    = 1'b1;
        if (acc_nz && acc_mark == d_mark) begin
          a_w = pack_word(sat_add(acc_mag, d_mag), d_mark);
        end else if (acc_nz) begin
          a_w = pack_word(acc_mag, acc_mark);
          b_v = 1'b1;
          b_w = pack_word(d_mag, d_mark);
        end else begin
          a_w = pack_word(d_mag, d_mark);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_mag  <= '0;
      acc_mark <= 1'b0;
      idle     <= 1'b1;
    end else begin
      acc_mag  <= acc_n;
      acc_mark <= accm_n;
      idle     <= idle_n;
    end
  end

  assert_zero_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (take && d_empty) |=> (!out_valid && $stable(acc_mag)));

  assert_idle_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (take && idle && d_ovf) |=> (!out_valid && idle));

  assert_wake_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (take && idle && !wide_mode && !d_empty && !d_ovf)
      |=> (out_valid && !out_word[MARK_POS] && !idle));

  assert_wake_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (take && idle && !wide_mode && !d_empty && !d_ovf && idle_drop) |=> !pend);

  assert_wide_plain_R12: assert property (@(posedge clk) disable iff (rst)
    (take && wide_mode && !d_empty) |=> (out_valid && idle == $past(idle)));

  assert_ovf_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (take && d_ovf && !idle && (!acc_nz || acc_mark == d_mark)) |=> !out_valid);
endmodule

// File: tb/tb_ir_run_combiner.sv
module tb_ir_run_combiner;
  localparam int unsigned MAXM = 32'hFFFFFF;

  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 1'b0, wide_mode = 1'b0, idle_drop = 1'b1, us_tick = 1'b0;
  logic [15:0] in_sample = '0;
  logic [7:0]  period_us = 8'd75;
  logic        in_ready, out_valid;
  logic [31:0] out_word;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$], got_q[$];
  int unsigned m_acc = 0, m_gap = 0;
  bit m_mark = 0, m_idle = 1;
  logic rdy;

  ir_run_combiner dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .wide_mode(wide_mode), .idle_drop(idle_drop),
    .period_us(period_us), .us_tick(us_tick), .out_valid(out_valid), .out_word(out_word)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && out_valid) got_q.push_back(out_word);

  function automatic int unsigned sat(input int unsigned a, input int unsigned b);
    longint s;
    s = longint'(a) + longint'(b);
    return (s > MAXM) ? MAXM : int'(s);
  endfunction

  function automatic logic [31:0] mk(input int unsigned m, input bit mark);
    return {7'd0, mark, m[23:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] s);
    int unsigned v, mag;
    bit mark;
    if (wide_mode) begin
      v = s[11:0]; mark = s[15]; mag = v * 61;
    end else begin
      v = s[6:0]; mark = !s[7]; mag = v * period_us;
    end
    if (v == 0) return;
    if (!wide_mode && v == 127) begin
      if (m_idle) return;
      if (m_acc == 0 || m_mark || m_acc <= 250000) begin
        if (m_acc != 0 && m_mark != mark) begin
          exp_q.push_back(mk(m_acc, m_mark)); m_acc = mag;
        end else m_acc = sat(m_acc, mag);
        m_mark = mark;
      end else begin
        m_idle = 1; m_gap = 0;
      end
      return;
    end
    if (m_idle && !wide_mode) begin
      exp_q.push_back(mk(sat(m_acc, m_gap), 0));
      m_acc = 0; m_mark = 0; m_idle = 0;
      if (!idle_drop) exp_q.push_back(mk(mag, mark));
      return;
    end
    if (m_acc != 0 && m_mark == mark) exp_q.push_back(mk(sat(m_acc, mag), mark));
    else if (m_acc != 0) begin
      exp_q.push_back(mk(m_acc, m_mark)); exp_q.push_back(mk(mag, mark));
    end else exp_q.push_back(mk(mag, mark));
    m_acc = 0; m_mark = 0;
  endtask

  task automatic send(input logic [15:0] s);
    @(negedge clk); in_sample = s; in_valid = 1'b1; model(s);
    @(negedge clk); in_valid = 1'b0; rdy = in_ready;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); us_tick = 1'b1; end
    @(negedge clk); us_tick = 1'b0;
    if (m_idle) m_gap = sat(m_gap, n);
  endtask

  task automatic compare(input string req);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s: word count actual=%0d expected=%0d", req, got_q.size(), exp_q.size());
    end else
      for (int i = 0; i < got_q.size(); i++) chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    #1_500_000ns;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R1/R9/R10: wake from reset idle, gap 5, waking sample dropped
    ticks(5); send(16'h000A); compare("R9 R10 wake after reset");
    // R2 narrow decode
    send(16'h000A); compare("R2 mark 10x75");
    send(16'h0085); chk(rdy == 1'b1, "R13 ready single word", {31'd0, rdy}, 32'd1);
    compare("R2 space 5x75");
    // R6 then R5 merge
    send(16'h007F); compare("R6 overflow mark silent");
    send(16'h0002); compare("R5 merged mark");
    // R5 flush and reload, R13 ready low
    send(16'h00FF); compare("R6 overflow space silent");
    send(16'h0003); chk(rdy == 1'b0, "R13 ready low while pending", {31'd0, rdy}, 32'd0);
    compare("R5 flush then sample");
    // R4 zero counts
    send(16'h0080); send(16'h0000); compare("R4 zero samples silent");
    send(16'h0001); compare("R4 accumulator untouched");
    // R7/R8 idle entry and ignored overflows, R10 keep waking sample
    period_us = 8'd255;
    for (int i = 0; i < 9; i++) send(16'h00FF);
    compare("R7 idle entry silent");
    ticks(7); send(16'h00FF); send(16'h007F); compare("R8 overflow ignored while idle");
    ticks(3); idle_drop = 1'b0; send(16'h0004); compare("R9 R10 gap plus kept sample");
    // R11 saturation via mark overflows
    for (int i = 0; i < 520; i++) send(16'h007F);
    compare("R11 no output during growth");
    send(16'h0001); compare("R11 saturated mark");
    // R3/R12 wide mode
    wide_mode = 1'b1;
    send(16'h800A); compare("R3 wide mark");
    send(16'h0005); compare("R3 wide space");
    send(16'h007F); compare("R12 wide 127 ordinary");
    wide_mode = 1'b0; idle_drop = 1'b1;
    for (int i = 0; i < 9; i++) send(16'h00FF);
    ticks(4); wide_mode = 1'b1;
    send(16'h8003); compare("R12 wide ignores idle");
    wide_mode = 1'b0; send(16'h0002); compare("R9 narrow wake after wide");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      logic [15:0] s;
      r = $urandom_range(0, 99);
      wide_mode = ($urandom_range(0, 9) == 0);
      idle_drop = $urandom_range(0, 1);
      case ($urandom_range(0, 2))
        0: period_us = 8'd75;
        1: period_us = 8'd50;
        default: period_us = 8'd200;
      endcase
      if (it % 50 == 25) begin
        wide_mode = 1'b0;
        for (int k = 0; k < 12; k++) send(16'h00FF);
      end
      s = 16'($urandom());
      if (!wide_mode && r < 15) s = {8'd0, s[7], 7'h7F};
      else if (r < 20) s = wide_mode ? {s[15:12], 12'd0} : {s[15:8], s[7], 7'd0};
      send(s);
      ticks($urandom_range(0, 3));
      compare("R5 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule